// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is an 8-bit countdown timer driven by the processor cycle clock. A bus write selects one of four prescale intervals through its address offset and loads the written byte into the counter. The counter then steps down by one each time the chosen interval elapses. When a decrement happens while the counter holds zero, the counter wraps to 0xFF and switches to a one-per-cycle rate. Software can then read how many cycles have passed since expiry. This fast rate lasts until the next write.

Out of reset the counter takes the value on a seed input instead of zero, so software may use it as a source of randomness. The timer also starts in its slowest interval, so a poll loop that waits for zero before any write still exits. A read strobe places the live count on the read data bus and has no effect on the count or the mode.

Top module: `interval_timer`

## Requirements
- R1: A synchronous active-high reset loads the counter from `seed` and clears the expired state.
- R2: After reset, and before any write, the interval is 1024 cycles, so the first decrement lands on the 1024th rising edge after the reset edge.
- R3: A write with `wr_addr` 0, 1, 2 or 3 selects an interval of 1, 8, 64 or 1024 cycles and loads `wr_data` into the counter. The first decrement follows exactly one interval of edges after the write edge, and later decrements follow at the same spacing.
- R4: Every write restarts the prescaler, so a rewrite in the middle of an interval gives a full new interval before the next decrement.
- R5: A decrement taken while the counter is 0x00 yields 0xFF and enters the one-decrement-per-cycle mode.
- R6: In that mode the counter decrements on every edge, wrapping through 0xFF repeatedly, until the next write restores the selected interval.
- R7: With `rd_en` high, `rd_data` shows the live count in the same cycle; with `rd_en` low it is 0x00. Reads never change the count or the mode.
- R8: In the one-per-cycle mode, a poll with a period of 5 cycles observes 0x00 within 256 polls. A poll with a period of 8 that starts two counts above a multiple of eight never observes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| seed | input | 8 | Counter value taken at reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Interval select offset (0..3) |
| wr_data | input | 8 | Value loaded into the counter |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Live count while reading, else zero |

## Verification
The assertions assume that the write strobe, offset and data are stable across each rising edge. They also assume that reset is held for at least one edge, so that the mode register and the prescaler start together. The bench changes every input only on the falling edge. It pulses the write strobe for exactly one cycle and applies reset for one whole cycle. It compares reads against a closed-form count derived from the interval, the loaded value and the number of edges since the last write.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int CNT_W   = 8;
    localparam int PRESC_W = 10;
    localparam int SEL_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        IVL_1    = 2'd0,
        IVL_8    = 2'd1,
        IVL_64   = 2'd2,
        IVL_1024 = 2'd3
    } ivl_e;

    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             expired;
    } cnt_state_t;

    // last prescaler value of an interval: 2^k - 1
    function automatic logic [PRESC_W-1:0] ivl_limit(ivl_e sel);
        int sh;
        case (sel)
            IVL_1:   sh = 0;
            IVL_8:   sh = 3;
            IVL_64:  sh = 6;
            default: sh = PRESC_W;
        endcase
        return PRESC_W'((32'd1 << sh) - 32'd1);
    endfunction

endpackage

// File: rtl/timer_mode.sv
module timer_mode
    import timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_addr,
    output ivl_e             sel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= IVL_1024;
        end else if (wr_en) begin
            sel <= ivl_e'(wr_addr);
        end
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(sel)); // R7

endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler
    import timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  ivl_e sel,
    input  logic fast,
    output logic tick
);

    logic [PRESC_W-1:0] presc;
    logic [PRESC_W-1:0] limit;
    logic               at_end;

    assign limit  = ivl_limit(sel);
    assign at_end = (presc == limit);
    assign tick   = fast | at_end;

    always_ff @(posedge clk) begin
        if (rst || restart || fast || at_end) begin
            presc <= '0;
        end else begin
            presc <= presc + 1'b1;
        end
    end

    AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (rst)
        presc <= ivl_limit(sel)); // R3

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        restart |=> presc == '0); // R4

endmodule

// File: rtl/timer_counter.sv
module timer_counter
    import timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] seed,
    input  logic             load,
    input  logic [CNT_W-1:0] load_data,
    input  logic             tick,
    output cnt_state_t       state
);

    cnt_state_t nxt;

    always_comb begin
        nxt = state;
        if (load) begin
            nxt.value   = load_data;
            nxt.expired = 1'b0;
        end else if (tick) begin
            nxt.value = state.value - 1'b1;
            if (state.value == '0) begin
                nxt.expired = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state.value   <= seed;
            state.expired <= 1'b0;
        end else begin
            state <= nxt;
        end
    end

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        load |=> (state.value == $past(load_data)) && !state.expired); // R3

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(state)); // R4

    AST_WRAP_TO_FF: assert property (@(posedge clk) disable iff (rst)
        (!load && tick && state.value == '0) |=> state.value == '1 && state.expired); // R5

    AST_EXPIRED_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state.expired && !load) |=> state.expired); // R6

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] seed,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [CNT_W-1:0] rd_data
);

    ivl_e       sel;
    logic       tick;
    cnt_state_t state;

    timer_mode u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .sel     (sel)
    );

    timer_prescaler u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (wr_en),
        .sel     (sel),
        .fast    (state.expired),
        .tick    (tick)
    );

    timer_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .seed      (seed),
        .load      (wr_en),
        .load_data (wr_data),
        .tick      (tick),
        .state     (state)
    );

    assign rd_data = rd_en ? state.value : '0;

    AST_FAST_RATE: assert property (@(posedge clk) disable iff (rst)
        (state.expired && !wr_en) |=> state.value == $past(state.value) - 8'd1); // R6

    AST_RESET_MODE: assert property (@(posedge clk)
        rst |=> sel == IVL_1024 && !state.expired); // R2

endmodule

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic [7:0] seed = 8'h00;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    int m_start = 0;
    int m_sel = 3;
    int elapsed = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    interval_timer u0 (
        .clk(clk), .rst(rst), .seed(seed),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data)
    );

    function automatic int ivl_len(int sel);
        return (sel == 3) ? 1024 : (1 << (3 * sel));
    endfunction

    // count after n edges since load of 'start' at interval 'sel'
    function automatic logic [7:0] exp_val(int start, int sel, int n);
        int iv = ivl_len(sel);
        int ticks = n / iv;
        if (ticks <= start) return 8'(start - ticks);
        return 8'(255 - ((n - (start + 1) * iv) % 256));
    endfunction

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic do_reset(input logic [7:0] s);
        @(negedge clk); rst = 1'b1; seed = s;
        @(negedge clk); rst = 1'b0;
        m_start = s; m_sel = 3; elapsed = 0;
    endtask

    task automatic do_write(input int a, input int d);
        @(negedge clk); wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        @(negedge clk); wr_en = 1'b0;
        m_start = d; m_sel = a; elapsed = 0;
    endtask

    task automatic adv(input int m);
        repeat (m) @(negedge clk);
        elapsed += m;
    endtask

    task automatic chk(input string req, output logic [7:0] got);
        logic [7:0] e;
        e = exp_val(m_start, m_sel, elapsed);
        rd_en = 1'b1;
        #0.5;
        got = rd_data;
        total++;
        if (got !== e) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h (sel=%0d start=%0d n=%0d)",
                     req, got, e, m_sel, m_start, elapsed);
        end
        rd_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] g;
        bit seen;
        void'($urandom(32'd20240611));

        // R1: seed loaded at reset
        do_reset(8'h5A);
        chk("R1", g);
        // R7: idle read bus is zero
        #0.5; total++;
        if (rd_data !== 8'h00) begin
            bad++; $display("FAIL R7: got %02h expected 00", rd_data);
        end
        // R2: power-up interval 1024
        adv(1023); chk("R2", g);
        adv(1);    chk("R2", g);
        adv(2047); chk("R2", g);

        // R5: wrap from zero at power-up mode
        do_reset(8'h00);
        adv(1023); chk("R5", g);
        adv(1);    chk("R5", g);
        adv(1);    chk("R6", g);

        // R3: each interval
        for (int a = 0; a < 4; a++) begin
            do_write(a, 3);
            adv(ivl_len(a) - 1); chk("R3", g);
            adv(1);              chk("R3", g);
            adv(ivl_len(a));     chk("R3", g);
        end

        // R4: rewrite restarts prescaler
        do_write(2, 10);
        adv(40); chk("R4", g);
        do_write(2, 10);
        adv(40); chk("R4", g);
        adv(24); chk("R4", g);

        // R5/R6: interval 8, expire and run fast through several wraps
        do_write(1, 1);
        adv(16); chk("R5", g);
        adv(1);  chk("R6", g);
        adv(600); chk("R6", g);
        do_write(1, 4);
        adv(8); chk("R6", g);

        // R8 + R7: period-5 poll finds zero, reads do not disturb
        do_write(0, 3);
        seen = 0;
        for (int i = 0; i < 256 && !seen; i++) begin
            adv(5); chk("R7", g);
            if (g == 8'h00) seen = 1;
        end
        total++;
        if (!seen) begin
            bad++; $display("FAIL R8: got no zero expected zero within 256 polls");
        end

        // R8: period-8 poll starting at 2 never sees zero
        do_write(0, 3);
        adv(1);
        seen = 0;
        for (int i = 0; i < 64; i++) begin
            chk("R8", g);
            if (g == 8'h00) seen = 1;
            adv(8);
        end
        total++;
        if (seen) begin
            bad++; $display("FAIL R8: got zero expected never zero");
        end

        // random mix, R3/R6
        for (int r = 0; r < 30; r++) begin
            do_write(int'($urandom_range(0, 3)), int'($urandom_range(0, 255)));
            for (int k = 0; k < 3; k++) begin
                adv(int'($urandom_range(0, 700)));
                chk("R3/R6 random", g);
            end
        end

        finished = 1;
        report();
        $finish;
    end

endmodule